// File: doc/BRIEF.md
# Synchronous Burst Read Sequencer

This block is the device-side read engine of a NOR-style memory. A host latches a start address with an address-valid strobe on an active edge of the memory clock pin. The sequencer then waits a programmable number of active edges, walks forward through consecutive addresses one word at a time, and places each word fetched from a plain combinational array port onto the data output. A wait indicator travels with the data, so the host knows which edges carry a valid word. The stream runs until it is aborted by a new strobe. Each time it steps into a new aligned group of 16 words, it pauses for a few extra edges.

A 16-bit configuration word sets the behaviour, and a dedicated load strobe writes it. This word chooses between the burst engine and a plain asynchronous mode in which the output follows the address input directly. It also sets the initial latency, the polarity of the wait indicator, and whether each word lasts one or two edges. It can move the wait indicator one data edge earlier, and it selects whether the rising or the falling edge of the memory clock pin counts. Finally, it decides whether the shared handshake pin acts as a wait output or as a ready input. In ready-input mode, the block reports that it is pulling the pin low during its start-up interval. After that interval, a high-low-high pattern on the pin re-arms an address latch on the next active edge.

The memory clock pin is sampled in the single system clock domain. Every burst action is tied to a detected active edge of that pin.

Top module: `burst_read_seq`

## Requirements
- R1: While reset is held, the configuration reads 16'h28D0. This means burst mode, latency 5, rising edge, ready-input mode, wait polarity low, single-edge words and normal wait timing. The start-up pull-low indicator is 1 and the wait output enable is 0.
- R2: A load of the configuration forces bit 7 to 1 and bits 14, 5 and 3..0 to 0, and keeps every other bit as written. If the written latency field (bits 13..11) is not 3, 4 or 5, it is stored as 5.
- R3: In burst mode (bit 15 = 0), the first word, for the latched address, appears on the data output after L active edges following the latching edge, where L is the latency field. Before that, the output is zero and the wait indicator is asserted.
- R4: In burst mode, addresses step up by one. With bit 9 = 0 each word lasts one active edge, and with bit 9 = 1 it lasts two.
- R5: When the address steps from a value whose low four bits are all ones to the next value, the output reads zero and the wait indicator stays asserted for L-1 active edges. After that, the word at the new address appears.
- R6: The wait pin is driven (enable = 1) only while bit 4 is 0. The driven level equals the internal wait state when bit 10 = 1 and its inverse when bit 10 = 0. In burst mode, wait is asserted whenever no burst word is being presented.
- R7: With bit 8 = 1, the wait indicator shows, one active edge ahead, the state it will have after the next edge. It deasserts one edge before the first word and one edge before the word that ends a boundary pause. It asserts while the last word before a boundary pause is shown.
- R8: Bit 6 = 1 makes rising edges of the memory clock pin the active ones, and bit 6 = 0 makes falling edges the active ones. Edges of the other direction do not advance the burst.
- R9: In asynchronous mode (bit 15 = 1), the array address equals the address input, the data output equals the array word with no clock delay, and the wait state is deasserted.
- R10: An address-valid strobe on an active edge during a burst drops the current burst and starts the latency count again for the new address.
- R11: In ready-input mode, the pull-low indicator stays 1 for INIT_CYCLES system clocks after reset and then stays 0. After that, the ready pin going high, then low, then high causes the address input to be latched on the next active edge, as if a strobe had been given.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| cfg_load | input | 1 | Configuration write strobe |
| cfg_wdata | input | 16 | Configuration write value |
| cfg_q | output | 16 | Current configuration word |
| k_in | input | 1 | Memory clock pin, sampled in the clk domain |
| adv | input | 1 | Address-valid strobe, taken on an active edge |
| addr_in | input | AW | Start address (burst) or read address (asynchronous) |
| rdy_in | input | 1 | Handshake pin level seen in ready-input mode |
| rdy_hold_low | output | 1 | Block pulls the handshake pin low during start-up |
| wait_out | output | 1 | Wait level driven on the handshake pin |
| wait_oe | output | 1 | Output enable of the handshake pin |
| mem_addr | output | AW | Address to the array |
| mem_rdata | input | DW | Array word for mem_addr, combinational |
| dout | output | DW | Data output, zero while no word is valid in burst mode |

## Verification
The assertions rely on the array port answering combinationally and on the configuration changing only through the load strobe. They also expect the memory clock pin and the strobes to change at most once per system clock. The stimulus changes every input on the falling system clock edge. It holds each memory clock level for at least two system clocks, so every active edge of the pin produces exactly one step. Configuration writes happen only between bursts or at a point where a restart is intended.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;

  localparam int CFG_W = 16;

  localparam int B_ASYNC  = 15;
  localparam int B_LAT_HI = 13;
  localparam int B_LAT_LO = 11;
  localparam int B_WPOL   = 10;
  localparam int B_HOLD2  = 9;
  localparam int B_EARLY  = 8;
  localparam int B_SEQ    = 7;
  localparam int B_EDGE   = 6;
  localparam int B_RDYIN  = 4;

  localparam logic [CFG_W-1:0] CFG_RESET = 16'h28D0;
  localparam logic [CFG_W-1:0] CFG_KEEP  = 16'hBFD0;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LAT  = 2'd1,
    ST_DATA = 2'd2,
    ST_GAP  = 2'd3
  } seq_state_e;

  function automatic logic [CFG_W-1:0] cfg_clean(input logic [CFG_W-1:0] w);
    logic [CFG_W-1:0] r;
    r = w & CFG_KEEP;
    r[B_SEQ] = 1'b1;
    if (w[B_LAT_HI:B_LAT_LO] < 3'd3 || w[B_LAT_HI:B_LAT_LO] > 3'd5)
      r[B_LAT_HI:B_LAT_LO] = 3'd5;
    return r;
  endfunction

endpackage

// File: rtl/burst_cfg_reg.sv
module burst_cfg_reg
  import burst_seq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CFG_W-1:0] wdata,
  output logic [CFG_W-1:0] cfg_q
);

  logic [CFG_W-1:0] cfg_r;
  logic [CFG_W-1:0] cfg_n;
  logic             cfg_en;

  always_comb begin
    cfg_en = load;
    cfg_n  = cfg_clean(wdata);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cfg_r <= CFG_RESET;
    else if (cfg_en) cfg_r <= cfg_n;
  end

  assign cfg_q = cfg_r;

endmodule

// File: rtl/burst_pin_ctl.sv
module burst_pin_ctl #(
  parameter int INIT_CYCLES = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic k_in,
  input  logic edge_rise,
  input  logic rdy_mode,
  input  logic rdy_in,
  output logic step,
  output logic hold_low,
  output logic retrig
);

  localparam int IW = $clog2(INIT_CYCLES + 1) + 1;

  typedef enum logic [1:0] {
    DT_IDLE = 2'd0,
    DT_HIGH = 2'd1,
    DT_LOW  = 2'd2
  } det_e;

  logic k_d;
  det_e det_r, det_n;
  logic det_act;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) k_d <= 1'b0;
    else        k_d <= k_in;
  end

  assign step = edge_rise ? (k_in & ~k_d) : (~k_in & k_d);

  generate
    if (INIT_CYCLES > 0) begin : g_init
      logic [IW-1:0] icnt_r, icnt_n;
      logic          icnt_en;
      always_comb begin
        icnt_en = (icnt_r != '0);
        icnt_n  = icnt_r - {{(IW-1){1'b0}}, 1'b1};
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       icnt_r <= IW'(INIT_CYCLES);
        else if (icnt_en) icnt_r <= icnt_n;
      end
      assign hold_low = icnt_en;
    end else begin : g_noinit
      assign hold_low = 1'b0;
    end
  endgenerate

  assign det_act = rdy_mode & ~hold_low;

  always_comb begin
    det_n  = det_r;
    retrig = 1'b0;
    if (!det_act) begin
      det_n = DT_IDLE;
    end else begin
      case (det_r)
        DT_IDLE: if (rdy_in)  det_n = DT_HIGH;
        DT_HIGH: if (!rdy_in) det_n = DT_LOW;
        DT_LOW:  if (rdy_in) begin
                   det_n  = DT_HIGH;
                   retrig = 1'b1;
                 end
        default: det_n = DT_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) det_r <= DT_IDLE;
    else        det_r <= det_n;
  end

endmodule

// File: rtl/burst_core.sv
module burst_core
  import burst_seq_pkg::*;
#(
  parameter int AW        = 16,
  parameter int WRAP_BITS = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sync_en,
  input  logic          step,
  input  logic          latch_ev,
  input  logic [AW-1:0] latch_addr,
  input  logic [2:0]    lat,
  input  logic          hold2,
  output logic [AW-1:0] cur_addr,
  output logic          valid,
  output logic          valid_next
);

  seq_state_e    st_r, st_n;
  logic [2:0]    cnt_r, cnt_n;
  logic [AW-1:0] addr_r, addr_n;
  logic          ph_r, ph_n;
  logic          at_edge;
  logic          last_beat;

  assign at_edge   = &addr_r[WRAP_BITS-1:0];
  assign last_beat = ~hold2 | ph_r;

  always_comb begin
    st_n   = st_r;
    cnt_n  = cnt_r;
    addr_n = addr_r;
    ph_n   = ph_r;
    if (!sync_en) begin
      st_n  = ST_IDLE;
      cnt_n = 3'd0;
      ph_n  = 1'b0;
    end else if (latch_ev) begin
      st_n   = ST_LAT;
      cnt_n  = lat;
      addr_n = latch_addr;
      ph_n   = 1'b0;
    end else if (step) begin
      case (st_r)
        ST_LAT, ST_GAP: begin
          if (cnt_r == 3'd1) begin
            st_n = ST_DATA;
            ph_n = 1'b0;
          end else begin
            cnt_n = cnt_r - 3'd1;
          end
        end
        ST_DATA: begin
          if (!last_beat) begin
            ph_n = 1'b1;
          end else begin
            ph_n   = 1'b0;
            addr_n = addr_r + {{(AW-1){1'b0}}, 1'b1};
            if (at_edge) begin
              st_n  = ST_GAP;
              cnt_n = lat - 3'd1;
            end
          end
        end
        default: st_n = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_r   <= ST_IDLE;
      cnt_r  <= 3'd0;
      addr_r <= '0;
      ph_r   <= 1'b0;
    end else begin
      st_r   <= st_n;
      cnt_r  <= cnt_n;
      addr_r <= addr_n;
      ph_r   <= ph_n;
    end
  end

  assign cur_addr   = addr_r;
  assign valid      = (st_r == ST_DATA);
  assign valid_next = ((st_r == ST_DATA) && !(last_beat && at_edge)) ||
                      (((st_r == ST_LAT) || (st_r == ST_GAP)) && (cnt_r == 3'd1));

endmodule

// File: rtl/burst_read_seq.sv
module burst_read_seq
  import burst_seq_pkg::*;
#(
  parameter int AW          = 16,
  parameter int DW          = 16,
  parameter int WRAP_BITS   = 4,
  parameter int INIT_CYCLES = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_load,
  input  logic [15:0]   cfg_wdata,
  output logic [15:0]   cfg_q,
  input  logic          k_in,
  input  logic          adv,
  input  logic [AW-1:0] addr_in,
  input  logic          rdy_in,
  output logic          rdy_hold_low,
  output logic          wait_out,
  output logic          wait_oe,
  output logic [AW-1:0] mem_addr,
  input  logic [DW-1:0] mem_rdata,
  output logic [DW-1:0] dout
);

  logic          step;
  logic          retrig;
  logic          pend_r, pend_n;
  logic          latch_ev;
  logic          sync_en;
  logic [AW-1:0] cur_addr;
  logic          valid;
  logic          valid_next;
  logic          wait_act;

  burst_cfg_reg i_cfg (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (cfg_load),
    .wdata (cfg_wdata),
    .cfg_q (cfg_q)
  );

  burst_pin_ctl #(.INIT_CYCLES(INIT_CYCLES)) i_pin (
    .clk       (clk),
    .rst_n     (rst_n),
    .k_in      (k_in),
    .edge_rise (cfg_q[B_EDGE]),
    .rdy_mode  (cfg_q[B_RDYIN]),
    .rdy_in    (rdy_in),
    .step      (step),
    .hold_low  (rdy_hold_low),
    .retrig    (retrig)
  );

  assign sync_en  = ~cfg_q[B_ASYNC];
  assign latch_ev = sync_en & step & (adv | pend_r);

  always_comb begin
    pend_n = pend_r;
    if (latch_ev || !sync_en) pend_n = 1'b0;
    if (retrig && sync_en)    pend_n = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_r <= 1'b0;
    else        pend_r <= pend_n;
  end

  burst_core #(.AW(AW), .WRAP_BITS(WRAP_BITS)) i_core (
    .clk        (clk),
    .rst_n      (rst_n),
    .sync_en    (sync_en),
    .step       (step),
    .latch_ev   (latch_ev),
    .latch_addr (addr_in),
    .lat        (cfg_q[B_LAT_HI:B_LAT_LO]),
    .hold2      (cfg_q[B_HOLD2]),
    .cur_addr   (cur_addr),
    .valid      (valid),
    .valid_next (valid_next)
  );

  always_comb begin
    if (!sync_en)              wait_act = 1'b0;
    else if (cfg_q[B_EARLY])   wait_act = ~valid_next;
    else                       wait_act = ~valid;
  end

  assign wait_oe  = ~cfg_q[B_RDYIN];
  assign wait_out = wait_oe & (cfg_q[B_WPOL] ? wait_act : ~wait_act);
  assign mem_addr = sync_en ? cur_addr : addr_in;
  assign dout     = (!sync_en || valid) ? mem_rdata : '0;

endmodule

// File: rtl/burst_read_seq_chk.sv
module burst_read_seq_chk #(
  parameter int AW = 16,
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic [15:0]   cfg_q,
  input logic          wait_oe,
  input logic          wait_out,
  input logic          rdy_hold_low,
  input logic [AW-1:0] addr_in,
  input logic [AW-1:0] mem_addr,
  input logic [DW-1:0] dout,
  input logic          latch_ev
);

  assert_cfg_seq_bit_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_q[7] == 1'b1);

  assert_cfg_lat_legal_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_q[13:11] >= 3'd3) && (cfg_q[13:11] <= 3'd5));

  assert_oe_mode_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wait_oe |-> !cfg_q[4]);

  assert_async_addr_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_q[15] |-> mem_addr == addr_in);

  assert_linear_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_q[15] && $past(!cfg_q[15]) && !$past(latch_ev) && (mem_addr != $past(mem_addr)))
      |-> (mem_addr == $past(mem_addr) + {{(AW-1){1'b0}}, 1'b1}));

  assert_nodata_in_wait_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wait_oe && !cfg_q[8] && !cfg_q[15] && (wait_out == cfg_q[10])) |-> dout == '0);

  assert_hold_low_once_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !rdy_hold_low |=> !rdy_hold_low);

endmodule

bind burst_read_seq burst_read_seq_chk #(.AW(AW), .DW(DW)) i_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cfg_q        (cfg_q),
  .wait_oe      (wait_oe),
  .wait_out     (wait_out),
  .rdy_hold_low (rdy_hold_low),
  .addr_in      (addr_in),
  .mem_addr     (mem_addr),
  .dout         (dout),
  .latch_ev     (latch_ev)
);

// File: tb/test_burst_read_seq.sv
`timescale 1ns/1ps
module test_burst_read_seq;

  localparam int AW = 16;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          cfg_load;
  logic [15:0]   cfg_wdata;
  logic [15:0]   cfg_q;
  logic          k_in;
  logic          adv;
  logic [AW-1:0] addr_in;
  logic          rdy_in;
  logic          rdy_hold_low;
  logic          wait_out;
  logic          wait_oe;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_rdata;
  logic [DW-1:0] dout;

  int n_tests = 0;
  int n_fail  = 0;

  always #2.5 clk = ~clk;

  function automatic logic [DW-1:0] word_of(input logic [AW-1:0] a);
    return DW'(a) ^ 16'hA5C3;
  endfunction

  assign mem_rdata = word_of(mem_addr);

  burst_read_seq i_burst_read_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_load     (cfg_load),
    .cfg_wdata    (cfg_wdata),
    .cfg_q        (cfg_q),
    .k_in         (k_in),
    .adv          (adv),
    .addr_in      (addr_in),
    .rdy_in       (rdy_in),
    .rdy_hold_low (rdy_hold_low),
    .wait_out     (wait_out),
    .wait_oe      (wait_oe),
    .mem_addr     (mem_addr),
    .mem_rdata    (mem_rdata),
    .dout         (dout)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic clocks(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic krise();
    @(negedge clk) k_in = 1'b1;
    @(negedge clk);
  endtask

  task automatic kfall();
    @(negedge clk) k_in = 1'b0;
    @(negedge clk);
  endtask

  task automatic kcycle(input int n);
    for (int i = 0; i < n; i++) begin
      krise();
      kfall();
    end
  endtask

  task automatic write_cfg(input logic [15:0] v);
    @(negedge clk) begin cfg_load = 1'b1; cfg_wdata = v; end
    @(negedge clk) cfg_load = 1'b0;
  endtask

  task automatic start_burst(input logic [AW-1:0] a);
    @(negedge clk) begin addr_in = a; adv = 1'b1; end
    kcycle(1);
    adv = 1'b0;
  endtask

  task automatic t_reset();
    rst_n = 1'b0; cfg_load = 1'b0; cfg_wdata = '0; k_in = 1'b0;
    adv = 1'b0; addr_in = '0; rdy_in = 1'b1;
    #12;
    check("R1 cfg at reset", 32'(cfg_q), 32'h28D0);
    check("R1 hold low at reset", 32'(rdy_hold_low), 32'd1);
    check("R1 oe at reset", 32'(wait_oe), 32'd0);
    @(negedge clk) rst_n = 1'b1;
    clocks(4);
    check("R11 hold low during start-up", 32'(rdy_hold_low), 32'd1);
    clocks(8);
    check("R11 hold low released", 32'(rdy_hold_low), 32'd0);
  endtask

  task automatic t_retrigger();
    addr_in = 16'h0080;
    kcycle(2);
    check("R11 no latch without pulse", 32'(dout), 32'd0);
    @(negedge clk) rdy_in = 1'b0;
    clocks(2);
    rdy_in = 1'b1;
    clocks(2);
    kcycle(1);
    kcycle(4);
    check("R11 retrigger latency not done", 32'(dout), 32'd0);
    kcycle(1);
    check("R11 retrigger first word", 32'(dout), 32'(word_of(16'h0080)));
  endtask

  task automatic t_cfg();
    write_cfg(16'h0000);
    check("R2 clamp zero latency", 32'(cfg_q), 32'h2880);
    write_cfg(16'hFFFF);
    check("R2 clamp and mask all ones", 32'(cfg_q), 32'hAFD0);
    write_cfg(16'h1C40);
    check("R2 legal latency kept", 32'(cfg_q), 32'h1CC0);
  endtask

  task automatic t_latency();
    write_cfg(16'h1C40);
    check("R6 oe when wait mode", 32'(wait_oe), 32'd1);
    start_burst(16'h0005);
    check("R3 wait after latch", 32'(wait_out), 32'd1);
    kcycle(2);
    check("R3 wait before latency", 32'(wait_out), 32'd1);
    check("R3 no data before latency", 32'(dout), 32'd0);
    kcycle(1);
    check("R3 wait clear at first word", 32'(wait_out), 32'd0);
    check("R3 first word", 32'(dout), 32'(word_of(16'h0005)));
    kcycle(1);
    check("R4 next word", 32'(dout), 32'(word_of(16'h0006)));
  endtask

  task automatic t_polarity();
    write_cfg(16'h1840);
    start_burst(16'h0002);
    check("R6 low polarity asserted", 32'(wait_out), 32'd0);
    kcycle(3);
    check("R6 low polarity released", 32'(wait_out), 32'd1);
    write_cfg(16'h1850);
    check("R6 ready mode no drive", 32'(wait_oe), 32'd0);
    check("R6 ready mode pin level", 32'(wait_out), 32'd0);
  endtask

  task automatic t_hold2();
    write_cfg(16'h1E40);
    start_burst(16'h0030);
    kcycle(3);
    check("R4 hold2 first", 32'(dout), 32'(word_of(16'h0030)));
    kcycle(1);
    check("R4 hold2 repeat", 32'(dout), 32'(word_of(16'h0030)));
    kcycle(1);
    check("R4 hold2 advance", 32'(dout), 32'(word_of(16'h0031)));
    kcycle(1);
    check("R4 hold2 repeat2", 32'(dout), 32'(word_of(16'h0031)));
    kcycle(1);
    check("R4 hold2 advance2", 32'(dout), 32'(word_of(16'h0032)));
  endtask

  task automatic t_boundary();
    write_cfg(16'h2440);
    start_burst(16'h000E);
    kcycle(4);
    check("R5 word E", 32'(dout), 32'(word_of(16'h000E)));
    kcycle(1);
    check("R5 word F", 32'(dout), 32'(word_of(16'h000F)));
    kcycle(1);
    check("R5 pause wait", 32'(wait_out), 32'd1);
    check("R5 pause no data", 32'(dout), 32'd0);
    check("R5 pause address", 32'(mem_addr), 32'h0010);
    kcycle(2);
    check("R5 pause still wait", 32'(wait_out), 32'd1);
    kcycle(1);
    check("R5 word after pause", 32'(dout), 32'(word_of(16'h0010)));
    check("R5 wait cleared", 32'(wait_out), 32'd0);
  endtask

  task automatic t_early();
    write_cfg(16'h1D40);
    start_burst(16'h001D);
    check("R7 early wait after latch", 32'(wait_out), 32'd1);
    kcycle(2);
    check("R7 early release", 32'(wait_out), 32'd0);
    check("R7 data not yet", 32'(dout), 32'd0);
    kcycle(1);
    check("R7 first word", 32'(dout), 32'(word_of(16'h001D)));
    kcycle(2);
    check("R7 last word before pause", 32'(dout), 32'(word_of(16'h001F)));
    check("R7 early assert", 32'(wait_out), 32'd1);
    kcycle(1);
    check("R7 pause wait", 32'(wait_out), 32'd1);
    kcycle(1);
    check("R7 early release after pause", 32'(wait_out), 32'd0);
    check("R7 pause no data", 32'(dout), 32'd0);
    kcycle(1);
    check("R7 word after pause", 32'(dout), 32'(word_of(16'h0020)));
  endtask

  task automatic t_edge();
    write_cfg(16'h1C00);
    start_burst(16'h0050);
    kcycle(2);
    krise();
    check("R8 rising edge ignored", 32'(wait_out), 32'd1);
    kfall();
    check("R8 falling edge counts wait", 32'(wait_out), 32'd0);
    check("R8 falling edge counts data", 32'(dout), 32'(word_of(16'h0050)));
  endtask

  task automatic t_abort();
    write_cfg(16'h1C40);
    start_burst(16'h0060);
    kcycle(4);
    check("R10 burst running", 32'(dout), 32'(word_of(16'h0061)));
    start_burst(16'h0070);
    check("R10 restart wait", 32'(wait_out), 32'd1);
    check("R10 restart no data", 32'(dout), 32'd0);
    kcycle(2);
    check("R10 restart latency", 32'(wait_out), 32'd1);
    kcycle(1);
    check("R10 new first word", 32'(dout), 32'(word_of(16'h0070)));
  endtask

  task automatic t_async();
    write_cfg(16'h9C40);
    @(negedge clk) addr_in = 16'h1234;
    #1;
    check("R9 async address", 32'(mem_addr), 32'h1234);
    check("R9 async data", 32'(dout), 32'(word_of(16'h1234)));
    check("R9 async wait off", 32'(wait_out), 32'd0);
    addr_in = 16'h0042;
    #1;
    check("R9 async follows", 32'(dout), 32'(word_of(16'h0042)));
  endtask

  initial begin
    t_reset();
    t_retrigger();
    t_cfg();
    t_latency();
    t_polarity();
    t_hold2();
    t_boundary();
    t_early();
    t_edge();
    t_abort();
    t_async();
    write_cfg(16'h28D0);
    t_retrigger();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #1000000;
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual running expected finished");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule